// File: doc/BRIEF.md
# Single-Precision Source and Result Modifier Unit

This block sits on both sides of a floating-point execution datapath. On the way in, it applies a per-source absolute-value flag and a per-source negate flag to a set of single-precision operands. On the way out, it applies two optional post-processing steps to the single-precision result. The first is an output scale by a power of two. The second is a saturation of the result into the unit interval.

The source modifiers act on every operation, whether its result is integer or float. The result modifiers act only when the operation is marked as producing a float. The output scale is also suppressed when the operating precision allows denormal outputs.

Scaling works by moving the exponent field. No rounding step is needed. A result that leaves the normal range becomes a signed infinity or a signed zero. All outputs pass through an optional register stage, selected by a parameter.

Top module: `fpmod_unit`

## Requirements
- R1: While `rst_n` is low, with the register stage enabled, every output reads zero on the following cycle.
- R2: Bits 30:0 of each modified source equal bits 30:0 of the matching input source.
- R3: For source k, `abs_sel[k]` first clears bit 31, and then `neg_sel[k]` inverts bit 31. With both flags set, bit 31 is 1. This holds for zero and NaN operands too. Source 0 is `src_in[0]`.
- R4: The source modifiers apply whatever the values of `fp_result`, `omod_code`, `clamp_en` and `denorm_out_en`.
- R5: When `fp_result` is 0, `res_out` equals `res_in`.
- R6: `omod_code` selects the output scale: 0 leaves the value unchanged, 1 multiplies by 2, 2 multiplies by 4 and 3 multiplies by 0.5. The scale is done by adding 1, adding 2 or subtracting 1 in the exponent field (bits 30:23) of a normal finite value. Sign and mantissa are kept.
- R7: A scaled exponent of 255 or more gives a signed infinity (exponent 255, mantissa 0). A scaled exponent of 0 gives a signed zero. A denormal input to a nonzero scale code also gives a signed zero.
- R8: Under any scale code, a NaN or infinity (exponent 255) passes through unchanged, and a signed zero stays the same signed zero.
- R9: When `denorm_out_en` is 1, the output scale is not applied.
- R10: When `clamp_en` and `fp_result` are both 1, the scaled value is clamped. NaN gives +0.0. Any value with bit 31 set, including -0.0, gives +0.0. Any positive value above 1.0 (0x3F800000), including +infinity, gives exactly 0x3F800000. Other values pass through.
- R11: With `REG_OUT` = 1, outputs reflect the inputs present at the previous rising clock edge. Before that edge they still show the earlier result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| src_in | input | NSRC x 32 | Raw single-precision source operands |
| abs_sel | input | NSRC | Per-source absolute-value flags |
| neg_sel | input | NSRC | Per-source negate flags |
| omod_code | input | 2 | Output scale selector |
| clamp_en | input | 1 | Clamp result into [0.0, 1.0] |
| fp_result | input | 1 | Result is floating point; enables scale and clamp |
| denorm_out_en | input | 1 | Denormal outputs allowed; disables the scale |
| res_in | input | 32 | Raw single-precision result |
| src_out | output | NSRC x 32 | Modified source operands |
| res_out | output | 32 | Modified result |

## Verification
With the default register stage, every source and result output is due exactly one rising edge after its inputs are applied. The bench drives each vector on a falling edge and compares on the next falling edge, once the register has captured the vector. One directed case also samples just after the new vector is driven and before the edge. It confirms that the old value still holds then, so a zero-latency path is caught. The sweep crosses sign, exponent corners and mantissa patterns with every scale code, clamp, float and denormal setting. The expected value is formed by integer exponent arithmetic in the bench.

// File: rtl/fpmod_pkg.sv
package fpmod_pkg;
    localparam int DW    = 32;
    localparam int EXP_W = 8;
    localparam int MAN_W = 23;
    localparam int EW1   = EXP_W + 1;

    localparam logic [EXP_W-1:0] EXP_ALL1 = {EXP_W{1'b1}};
    localparam logic [DW-1:0]    FP_ONE   = {2'b00, {(EXP_W-1){1'b1}}, {MAN_W{1'b0}}};

    typedef enum logic [1:0] {
        SCALE_NONE = 2'd0,
        SCALE_X2   = 2'd1,
        SCALE_X4   = 2'd2,
        SCALE_HALF = 2'd3
    } scale_e;

    typedef struct packed {
        logic             sgn;
        logic [EXP_W-1:0] ex;
        logic [MAN_W-1:0] mn;
    } fp32_t;
endpackage

// File: rtl/fpmod_src.sv
module fpmod_src
    import fpmod_pkg::*;
(
    input  logic [DW-1:0] val_i,
    input  logic          abs_i,
    input  logic          neg_i,
    output logic [DW-1:0] val_o
);
    logic mag_sgn;

    always_comb begin
        mag_sgn = abs_i ? 1'b0 : val_i[DW-1];
        val_o   = {mag_sgn ^ neg_i, val_i[DW-2:0]};
    end
endmodule

// File: rtl/fpmod_scale.sv
module fpmod_scale
    import fpmod_pkg::*;
(
    input  logic [DW-1:0] val_i,
    input  logic [1:0]    code_i,
    input  logic          en_i,
    output logic [DW-1:0] val_o
);
    fp32_t          f;
    logic [EW1-1:0] e_adj;

    always_comb begin
        f     = fp32_t'(val_i);
        e_adj = {1'b0, f.ex};
        val_o = val_i;
        if (en_i && scale_e'(code_i) != SCALE_NONE && f.ex != EXP_ALL1) begin
            if (f.ex == '0) begin
                val_o = {f.sgn, {(DW-1){1'b0}}};
            end else begin
                unique case (scale_e'(code_i))
                    SCALE_X2:   e_adj = {1'b0, f.ex} + EW1'(1);
                    SCALE_X4:   e_adj = {1'b0, f.ex} + EW1'(2);
                    SCALE_HALF: e_adj = {1'b0, f.ex} - EW1'(1);
                    default:    e_adj = {1'b0, f.ex};
                endcase
                if (e_adj >= {1'b0, EXP_ALL1})
                    val_o = {f.sgn, EXP_ALL1, {MAN_W{1'b0}}};
                else if (e_adj == '0)
                    val_o = {f.sgn, {(DW-1){1'b0}}};
                else
                    val_o = {f.sgn, e_adj[EXP_W-1:0], f.mn};
            end
        end
    end
endmodule

// File: rtl/fpmod_clamp.sv
module fpmod_clamp
    import fpmod_pkg::*;
(
    input  logic [DW-1:0] val_i,
    input  logic          en_i,
    output logic [DW-1:0] val_o
);
    fp32_t f;
    logic  is_nan;

    always_comb begin
        f      = fp32_t'(val_i);
        is_nan = (f.ex == EXP_ALL1) && (f.mn != '0);
        val_o  = val_i;
        if (en_i) begin
            if (is_nan || f.sgn)
                val_o = '0;
            else if (val_i > FP_ONE)
                val_o = FP_ONE;
        end
    end
endmodule

// File: rtl/fpmod_unit.sv
module fpmod_unit
    import fpmod_pkg::*;
#(
    parameter int NSRC    = 3,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NSRC-1:0][DW-1:0]  src_in,
    input  logic [NSRC-1:0]          abs_sel,
    input  logic [NSRC-1:0]          neg_sel,
    input  logic [1:0]               omod_code,
    input  logic                     clamp_en,
    input  logic                     fp_result,
    input  logic                     denorm_out_en,
    input  logic [DW-1:0]            res_in,
    output logic [NSRC-1:0][DW-1:0]  src_out,
    output logic [DW-1:0]            res_out
);
    typedef struct packed {
        logic [NSRC-1:0][DW-1:0] srcs;
        logic [DW-1:0]           res;
    } out_t;

    logic [NSRC-1:0][DW-1:0] src_mod;
    logic [DW-1:0]           res_scaled;
    logic [DW-1:0]           res_clamped;
    logic                    scale_on;
    logic                    clamp_on;
    out_t                    out_d;

    for (genvar k = 0; k < NSRC; k++) begin : g_src
        fpmod_src u_src (
            .val_i (src_in[k]),
            .abs_i (abs_sel[k]),
            .neg_i (neg_sel[k]),
            .val_o (src_mod[k])
        );
    end

    assign scale_on = fp_result && !denorm_out_en;
    assign clamp_on = fp_result && clamp_en;

    fpmod_scale u_scale (
        .val_i  (res_in),
        .code_i (omod_code),
        .en_i   (scale_on),
        .val_o  (res_scaled)
    );

    fpmod_clamp u_clamp (
        .val_i (res_scaled),
        .en_i  (clamp_on),
        .val_o (res_clamped)
    );

    always_comb begin
        out_d.srcs = src_mod;
        out_d.res  = res_clamped;
    end

    if (REG_OUT) begin : g_reg
        out_t out_q;
        always_ff @(posedge clk) begin
            if (!rst_n) out_q <= '0;
            else        out_q <= out_d;
        end
        assign src_out = out_q.srcs;
        assign res_out = out_q.res;
    end else begin : g_comb
        assign src_out = out_d.srcs;
        assign res_out = out_d.res;
    end
endmodule

// File: rtl/fpmod_unit_chk.sv
module fpmod_unit_chk
    import fpmod_pkg::*;
#(
    parameter int NSRC    = 3,
    parameter bit REG_OUT = 1'b1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NSRC-1:0][DW-1:0]  src_in,
    input logic [NSRC-1:0]          abs_sel,
    input logic [NSRC-1:0]          neg_sel,
    input logic [1:0]               omod_code,
    input logic                     clamp_en,
    input logic                     fp_result,
    input logic                     denorm_out_en,
    input logic [DW-1:0]            res_in,
    input logic [NSRC-1:0][DW-1:0]  src_out,
    input logic [DW-1:0]            res_out
);
    if (REG_OUT) begin : g_seq
        a_r2_mag_kept: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> src_out[0][DW-2:0] == $past(src_in[0][DW-2:0]));

        a_r3_both_negative: assert property (@(posedge clk) disable iff (!rst_n)
            (abs_sel[0] && neg_sel[0]) |=> src_out[0][DW-1]);

        a_r3_abs_positive: assert property (@(posedge clk) disable iff (!rst_n)
            (abs_sel[NSRC-1] && !neg_sel[NSRC-1]) |=> !src_out[NSRC-1][DW-1]);

        a_r5_int_pass: assert property (@(posedge clk) disable iff (!rst_n)
            !fp_result |=> res_out == $past(res_in));

        a_r8_special_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (fp_result && !clamp_en && res_in[DW-2:MAN_W] == EXP_ALL1)
            |=> res_out == $past(res_in));

        a_r9_no_scale: assert property (@(posedge clk) disable iff (!rst_n)
            (fp_result && denorm_out_en && !clamp_en) |=> res_out == $past(res_in));

        a_r10_clamp_range: assert property (@(posedge clk) disable iff (!rst_n)
            (fp_result && clamp_en) |=> (!res_out[DW-1] && res_out <= FP_ONE));
    end
endmodule

bind fpmod_unit fpmod_unit_chk #(.NSRC(NSRC), .REG_OUT(REG_OUT)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .src_in        (src_in),
    .abs_sel       (abs_sel),
    .neg_sel       (neg_sel),
    .omod_code     (omod_code),
    .clamp_en      (clamp_en),
    .fp_result     (fp_result),
    .denorm_out_en (denorm_out_en),
    .res_in        (res_in),
    .src_out       (src_out),
    .res_out       (res_out)
);

// File: tb/fpmod_unit_bench.sv
module fpmod_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 3;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [NSRC-1:0][31:0]  src_in = '0;
    logic [NSRC-1:0]        abs_sel = '0;
    logic [NSRC-1:0]        neg_sel = '0;
    logic [1:0]             omod_code = '0;
    logic                   clamp_en = 1'b0;
    logic                   fp_result = 1'b0;
    logic                   denorm_out_en = 1'b0;
    logic [31:0]            res_in = '0;
    logic [NSRC-1:0][31:0]  src_out;
    logic [31:0]            res_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpmod_unit #(.NSRC(NSRC), .REG_OUT(1'b1)) u_fpmod_unit (
        .clk (clk), .rst_n (rst_n), .src_in (src_in), .abs_sel (abs_sel),
        .neg_sel (neg_sel), .omod_code (omod_code), .clamp_en (clamp_en),
        .fp_result (fp_result), .denorm_out_en (denorm_out_en),
        .res_in (res_in), .src_out (src_out), .res_out (res_out)
    );

    function automatic logic [31:0] ref_src(logic [31:0] v, logic a, logic n);
        logic s;
        s = (a ? 1'b0 : v[31]) ^ n;
        return {s, v[30:0]};
    endfunction

    function automatic logic [31:0] ref_res(logic [31:0] r, logic [1:0] om,
                                            logic cl, logic fp, logic dn);
        logic [31:0] x;
        int          ex;
        int          step;
        x  = r;
        ex = int'(r[30:23]);
        if (!fp) return r;
        if (!dn && om != 2'd0 && ex != 255) begin
            step = (om == 2'd1) ? 1 : (om == 2'd2) ? 2 : -1;
            if (ex == 0)                x = {r[31], 31'd0};
            else if (ex + step >= 255)  x = {r[31], 8'hFF, 23'd0};
            else if (ex + step <= 0)    x = {r[31], 31'd0};
            else                        x = {r[31], 8'(ex + step), r[22:0]};
        end
        if (cl) begin
            if (x[30:23] == 8'hFF && x[22:0] != 0) x = 32'd0;
            else if (x[31])                        x = 32'd0;
            else if (x > 32'h3F80_0000)            x = 32'h3F80_0000;
        end
        return x;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic drive(logic [31:0] s0, logic [31:0] s1, logic [31:0] s2,
                         logic [2:0] ab, logic [2:0] ng, logic [1:0] om,
                         logic cl, logic fp, logic dn, logic [31:0] r);
        src_in[0] = s0; src_in[1] = s1; src_in[2] = s2;
        abs_sel = ab; neg_sel = ng; omod_code = om;
        clamp_en = cl; fp_result = fp; denorm_out_en = dn; res_in = r;
    endtask

    task automatic res_case(string tag, logic [31:0] r, logic [1:0] om,
                            logic cl, logic [31:0] exp);
        @(negedge clk);
        drive(32'd0, 32'd0, 32'd0, 3'b000, 3'b000, om, cl, 1'b1, 1'b0, r);
        @(negedge clk);
        check(tag, res_out, exp);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] exps [13];
        logic [22:0] mans [4];
        exps = '{0, 1, 2, 3, 100, 126, 127, 128, 200, 252, 253, 254, 255};
        mans = '{23'd0, 23'd1, 23'h40_0000, 23'h7F_FFFF};

        // R1: reset clears outputs
        drive(32'hFFFF_FFFF, 32'h1234_5678, 32'h8000_0001, 3'b111, 3'b101,
              2'd1, 1'b0, 1'b0, 1'b0, 32'hDEAD_BEEF);
        repeat (3) @(negedge clk);
        check("R1 src0", src_out[0], 32'd0);
        check("R1 src2", src_out[2], 32'd0);
        check("R1 res", res_out, 32'd0);
        rst_n = 1'b1;

        // R3: directed sign handling on zero and NaN
        @(negedge clk);
        drive(32'h8000_0000, 32'h7FC0_0001, 32'hFFC0_0000, 3'b001, 3'b110,
              2'd0, 1'b0, 1'b1, 1'b0, 32'd0);
        @(negedge clk);
        check("R3 abs -0", src_out[0], 32'h0000_0000);
        check("R3 neg NaN", src_out[1], 32'hFFC0_0001);
        check("R3 neg NaN2", src_out[2], 32'h7FC0_0000);

        // R4: source modifiers with integer result
        @(negedge clk);
        drive(32'h8000_0005, 32'h0000_0007, 32'h3F80_0000, 3'b011, 3'b011,
              2'd3, 1'b1, 1'b0, 1'b1, 32'h8000_0003);
        @(negedge clk);
        check("R4 src0", src_out[0], 32'h8000_0005);
        check("R4 src1", src_out[1], 32'h8000_0007);
        check("R4 src2", src_out[2], 32'h3F80_0000);
        check("R5 int res", res_out, 32'h8000_0003);

        // R6 scale codes
        res_case("R6 x2",   32'h3F80_0000, 2'd1, 1'b0, 32'h4000_0000);
        res_case("R6 x4",   32'h3FC0_0000, 2'd2, 1'b0, 32'h40C0_0000);
        res_case("R6 half", 32'hBF80_0000, 2'd3, 1'b0, 32'hBF00_0000);
        res_case("R6 none", 32'h4049_0FDB, 2'd0, 1'b0, 32'h4049_0FDB);
        // R7 overflow / underflow
        res_case("R7 ovf",  32'h7F00_0000, 2'd1, 1'b0, 32'h7F80_0000);
        res_case("R7 ovf4", 32'hFE80_0001, 2'd2, 1'b0, 32'hFF80_0000);
        res_case("R7 unf",  32'h8080_0000, 2'd3, 1'b0, 32'h8000_0000);
        res_case("R7 den",  32'h0000_0FFF, 2'd2, 1'b0, 32'h0000_0000);
        // R8 specials
        res_case("R8 nan",  32'h7FC0_0001, 2'd2, 1'b0, 32'h7FC0_0001);
        res_case("R8 -inf", 32'hFF80_0000, 2'd3, 1'b0, 32'hFF80_0000);
        res_case("R8 -0",   32'h8000_0000, 2'd1, 1'b0, 32'h8000_0000);
        // R10 clamp, after scale
        res_case("R10 after x2", 32'h3F40_0000, 2'd1, 1'b1, 32'h3F80_0000);
        res_case("R10 in range", 32'h3EC0_0000, 2'd1, 1'b1, 32'h3F40_0000);
        res_case("R10 nan",  32'h7FC0_0000, 2'd0, 1'b1, 32'h0000_0000);
        res_case("R10 -0",   32'h8000_0000, 2'd0, 1'b1, 32'h0000_0000);
        res_case("R10 +inf", 32'h7F80_0000, 2'd0, 1'b1, 32'h3F80_0000);

        // R9 denormal-output mode ignores scale
        @(negedge clk);
        drive(32'd0, 32'd0, 32'd0, 3'b000, 3'b000, 2'd2, 1'b0, 1'b1, 1'b1, 32'h3F80_0000);
        @(negedge clk);
        check("R9 no scale", res_out, 32'h3F80_0000);

        // R11: latency of one edge
        drive(32'd0, 32'd0, 32'd0, 3'b000, 3'b000, 2'd1, 1'b0, 1'b1, 1'b0, 32'h4000_0000);
        #1;
        check("R11 hold", res_out, 32'h3F80_0000);
        @(negedge clk);
        check("R11 update", res_out, 32'h4080_0000);

        // Sweep: R2 R3 R5 R6 R7 R8 R9 R10
        for (int ei = 0; ei < 13; ei++) begin
            for (int mi = 0; mi < 4; mi++) begin
                for (int sg = 0; sg < 2; sg++) begin
                    for (int cfg = 0; cfg < 32; cfg++) begin
                        logic [31:0] r;
                        logic [1:0]  om;
                        logic        cl, fp, dn;
                        logic [2:0]  ab, ng;
                        string       tag;
                        r  = {sg[0], exps[ei][7:0], mans[mi]};
                        om = cfg[1:0]; cl = cfg[2]; fp = cfg[3]; dn = cfg[4];
                        ab = 3'(cfg + ei);
                        ng = 3'(cfg + mi + sg);
                        @(negedge clk);
                        drive(r, ~r, r ^ 32'h8000_0001, ab, ng, om, cl, fp, dn, r);
                        @(negedge clk);
                        if (!fp)      tag = "R5 sweep";
                        else if (cl)  tag = "R10 sweep";
                        else if (dn)  tag = "R9 sweep";
                        else          tag = "R6/R7/R8 sweep";
                        check(tag, res_out, ref_res(r, om, cl, fp, dn));
                        check("R2/R3 sweep src0", src_out[0], ref_src(r, ab[0], ng[0]));
                        check("R2/R3 sweep src1", src_out[1], ref_src(~r, ab[1], ng[1]));
                        check("R2/R3 sweep src2", src_out[2], ref_src(r ^ 32'h8000_0001, ab[2], ng[2]));
                    end
                end
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule